// File: doc/BRIEF.md
# Torus Network Packet Router

This block is the switching core of one node in a three-dimensional torus network. It has seven input and seven output flit channels: one per direction along X, Y and Z, plus one for the local host. Every packet starts with a header flit that names a destination coordinate. The router compares that coordinate with the node's own coordinate, picks an output, and moves the whole packet across a 7x7 crossbar. No software step is needed at any hop.

Each input channel feeds a small FIFO. The route is worked out from the header at the FIFO head, in dimension order. Each output has its own arbiter state machine with two states. ARB_IDLE waits for header requests and takes the **grant** transition to ARB_BUSY, recording the winning input. ARB_BUSY streams that input's flits and takes the **release** transition back to ARB_IDLE when the flit carrying the end-of-packet flag leaves. The node coordinate and the ring length of each dimension are static inputs, so one build serves any torus size up to 16 nodes per ring.

Top module: `torus_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A packet whose destination X, Y and Z all equal the node coordinate leaves on the local port, index 6.
- R3: Routing is dimension-ordered. A packet whose X differs from the node's goes to an X port whatever its Y and Z are. A packet whose X matches goes to a Y port if its Y differs. Z is corrected only when X and Y both match.
- R4: In each dimension, the direction is chosen by the shorter way around a ring of the configured length. The forward distance is (dest - own) mod ring. Plus is chosen when that distance is at most ring minus that distance, so a tie goes to plus.
- R5: Output and input indices are fixed: 0 X+, 1 X-, 2 Y+, 3 Y-, 4 Z+, 5 Z-, 6 local. In the header flit, the destination X is in bits [3:0], Y in [7:4], Z in [11:8], and the payload length in 16-byte words in [23:12].
- R6: Once a header is granted to an output, every flit of that packet leaves that output in order, up to and including the flit whose `in_eop` flag is set. No other input's flit appears on that output in between.
- R7: Each output arbitrates round-robin. The search pointer is 0 after reset. After a packet ends, the pointer moves to one past the input that sent it, so among simultaneous headers the first requesting input at or after the pointer wins.
- R8: While `out_valid` is high and `out_ready` is low, the output holds its valid and its data. An input FIFO deasserts `in_ready` when it is full and drops no flit.
- R9: Every flit accepted on an input leaves on the routed output exactly once. Flits from one input to one output keep their order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | COORD_W | Node X coordinate |
| my_y | input | COORD_W | Node Y coordinate |
| my_z | input | COORD_W | Node Z coordinate |
| ring_x | input | COORD_W+1 | Number of nodes on the X ring |
| ring_y | input | COORD_W+1 | Number of nodes on the Y ring |
| ring_z | input | COORD_W+1 | Number of nodes on the Z ring |
| in_valid | input | 7 | Per-input flit valid |
| in_ready | output | 7 | Per-input FIFO has room |
| in_data | input | 7*DATA_W | Per-input flit data, input i in slice i |
| in_eop | input | 7 | Per-input last-flit flag |
| out_valid | output | 7 | Per-output flit valid |
| out_ready | input | 7 | Per-output downstream ready |
| out_data | output | 7*DATA_W | Per-output flit data, output o in slice o |
| out_eop | output | 7 | Per-output last-flit flag |

## Verification
Single packets are sent one at a time to destinations chosen to separate cases. A matching coordinate tests local delivery. A near target tests a short forward hop. A far target tests the wraparound minus choice. An exactly-half target tests the tie rule. A packet with mismatches in several dimensions shows that X is corrected first. The same X target is then sent again after the X ring length is changed, which shows that direction depends on the configured ring size and not only on the coordinates. Pairs of packets released in the same cycle toward one output reveal the grant order: a fixed-priority scheme and a moving round-robin pointer give different orders in the second round. A long packet against a stalled output shows both the hold behaviour and FIFO backpressure.

// File: rtl/torus_pkg.sv
package torus_pkg;
    localparam int NPORT = 7;
    localparam int PIDX_W = 3;

    typedef enum logic [PIDX_W-1:0] {
        PORT_XP  = 3'd0,
        PORT_XM  = 3'd1,
        PORT_YP  = 3'd2,
        PORT_YM  = 3'd3,
        PORT_ZP  = 3'd4,
        PORT_ZM  = 3'd5,
        PORT_LOC = 3'd6
    } port_e;

    typedef enum logic {
        ARB_IDLE,
        ARB_BUSY
    } arb_state_e;
endpackage

// File: rtl/torus_in_fifo.sv
module torus_in_fifo #(
    parameter int W     = 129,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign push_ready = (fill != CW'(DEPTH));
    assign head_valid = (fill != '0);
    assign head_data  = slots[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready && !pop) |=> (fill == $past(fill)));
endmodule

// File: rtl/torus_route_calc.sv
module torus_route_calc
    import torus_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0] own_x,
    input  logic [CW-1:0] own_y,
    input  logic [CW-1:0] own_z,
    input  logic [CW:0]   len_x,
    input  logic [CW:0]   len_y,
    input  logic [CW:0]   len_z,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] dst_z,
    output port_e         sel
);
    // 0: aligned, 1: go plus, 2: go minus
    function automatic logic [1:0] way(input logic [CW-1:0] c, input logic [CW-1:0] d,
                                       input logic [CW:0] n);
        logic [CW:0] fwd;
        if (d >= c) fwd = {1'b0, d} - {1'b0, c};
        else        fwd = {1'b0, d} + n - {1'b0, c};
        if (d == c)             way = 2'd0;
        else if (fwd <= n - fwd) way = 2'd1;
        else                    way = 2'd2;
    endfunction

    logic [1:0] wx, wy, wz;

    always_comb begin
        wx = way(own_x, dst_x, len_x);
        wy = way(own_y, dst_y, len_y);
        wz = way(own_z, dst_z, len_z);
        if (wx != 2'd0)      sel = (wx == 2'd1) ? PORT_XP : PORT_XM;
        else if (wy != 2'd0) sel = (wy == 2'd1) ? PORT_YP : PORT_YM;
        else if (wz != 2'd0) sel = (wz == 2'd1) ? PORT_ZP : PORT_ZM;
        else                 sel = PORT_LOC;
    end
endmodule

// File: rtl/torus_out_arb.sv
module torus_out_arb
    import torus_pkg::*;
#(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          fire,
    input  logic          last,
    output logic          busy,
    output logic [IW-1:0] owner
);
    arb_state_e    state, state_d;
    logic [IW-1:0] owner_d, rr_q, rr_d, pick;
    logic          found;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(rr_q) + k) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
            owner <= '0;
            rr_q  <= '0;
        end else begin
            state <= state_d;
            owner <= owner_d;
            rr_q  <= rr_d;
        end
    end

    always_comb begin
        state_d = state;
        owner_d = owner;
        rr_d    = rr_q;
        unique case (state)
            ARB_IDLE: if (found) begin
                state_d = ARB_BUSY;
                owner_d = pick;
            end
            ARB_BUSY: if (fire && last) begin
                state_d = ARB_IDLE;
                rr_d    = (int'(owner) == N - 1) ? '0 : owner + 1'b1;
            end
        endcase
    end

    assign busy = (state == ARB_BUSY);

    // R6
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(fire && last)) |=> (busy && $stable(owner)));
endmodule

// File: rtl/torus_router.sv
module torus_router
    import torus_pkg::*;
#(
    parameter int DATA_W     = 128,
    parameter int COORD_W    = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COORD_W-1:0]      my_x,
    input  logic [COORD_W-1:0]      my_y,
    input  logic [COORD_W-1:0]      my_z,
    input  logic [COORD_W:0]        ring_x,
    input  logic [COORD_W:0]        ring_y,
    input  logic [COORD_W:0]        ring_z,
    input  logic [NPORT-1:0]        in_valid,
    output logic [NPORT-1:0]        in_ready,
    input  logic [NPORT*DATA_W-1:0] in_data,
    input  logic [NPORT-1:0]        in_eop,
    output logic [NPORT-1:0]        out_valid,
    input  logic [NPORT-1:0]        out_ready,
    output logic [NPORT*DATA_W-1:0] out_data,
    output logic [NPORT-1:0]        out_eop
);
    localparam int FW = DATA_W + 1;

    logic [FW-1:0]     head   [NPORT];
    logic [NPORT-1:0]  head_v;
    logic [NPORT-1:0]  at_hdr;
    logic [NPORT-1:0]  pop;
    port_e             sel    [NPORT];
    logic [NPORT-1:0]  req_o  [NPORT];
    logic [NPORT-1:0]  gnt_o  [NPORT];
    logic [NPORT-1:0]  busy;
    logic [PIDX_W-1:0] owner  [NPORT];

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        torus_in_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk, .rst_n,
            .push_valid (in_valid[i]),
            .push_ready (in_ready[i]),
            .push_data  ({in_eop[i], in_data[i*DATA_W +: DATA_W]}),
            .pop        (pop[i]),
            .head_valid (head_v[i]),
            .head_data  (head[i])
        );

        torus_route_calc #(.CW(COORD_W)) u_route (
            .own_x (my_x), .own_y (my_y), .own_z (my_z),
            .len_x (ring_x), .len_y (ring_y), .len_z (ring_z),
            .dst_x (head[i][COORD_W-1:0]),
            .dst_y (head[i][2*COORD_W-1:COORD_W]),
            .dst_z (head[i][3*COORD_W-1:2*COORD_W]),
            .sel   (sel[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      at_hdr[i] <= 1'b1;
            else if (pop[i]) at_hdr[i] <= head[i][DATA_W];
        end

        for (genvar o = 0; o < NPORT; o++) begin : g_req
            assign req_o[o][i] = head_v[i] && at_hdr[i] && (int'(sel[i]) == o);
        end

        always_comb begin
            pop[i] = 1'b0;
            for (int o = 0; o < NPORT; o++)
                if (gnt_o[o][i] && out_ready[o]) pop[i] = head_v[i];
        end

        // R2
        local_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (head_v[i] && at_hdr[i] && sel[i] == PORT_LOC) |->
            (head[i][3*COORD_W-1:0] == {my_z, my_y, my_x}));

        // R6
        one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({gnt_o[6][i], gnt_o[5][i], gnt_o[4][i], gnt_o[3][i],
                        gnt_o[2][i], gnt_o[1][i], gnt_o[0][i]}) <= 1);
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        logic [FW-1:0] cur;

        torus_out_arb #(.N(NPORT), .IW(PIDX_W)) u_arb (
            .clk, .rst_n,
            .req   (req_o[o]),
            .fire  (out_valid[o] && out_ready[o]),
            .last  (out_eop[o]),
            .busy  (busy[o]),
            .owner (owner[o])
        );

        assign gnt_o[o]  = busy[o] ? (NPORT'(1) << owner[o]) : '0;
        assign cur       = head[owner[o]];
        assign out_valid[o] = busy[o] && head_v[owner[o]];
        assign out_eop[o]   = cur[DATA_W];
        assign out_data[o*DATA_W +: DATA_W] = cur[DATA_W-1:0];

        // R8
        out_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o]) |=>
            (out_valid[o] && $stable(out_data[o*DATA_W +: DATA_W])));
    end
endmodule

// File: tb/torus_router_tb.sv
module torus_router_tb;
    localparam int NP = 7;
    localparam int DW = 128;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [3:0]      my_x = 4'd2, my_y = 4'd3, my_z = 4'd1;
    logic [4:0]      ring_x = 5'd8, ring_y = 5'd8, ring_z = 5'd4;
    logic [NP-1:0]   in_valid = '0, in_eop = '0, in_ready;
    logic [DW-1:0]   drv [NP];
    logic [NP*DW-1:0] in_data, out_data;
    logic [NP-1:0]   out_valid, out_eop;
    logic [NP-1:0]   out_ready = '1;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < NP; i++) in_data[i*DW +: DW] = drv[i];

    torus_router u_dut (
        .clk, .rst_n, .my_x, .my_y, .my_z, .ring_x, .ring_y, .ring_z,
        .in_valid, .in_ready, .in_data, .in_eop,
        .out_valid, .out_ready, .out_data, .out_eop
    );

    int checks = 0, errors = 0, cyc = 0, seq = 0;
    logic [DW:0] exp_q [NP*NP][$];
    int order_q [$];
    int cur_src [NP];

    function automatic int pick_dir(int c, int d, int n, int pl, int mi);
        int fwd;
        fwd = (d - c + n) % n;
        return (fwd <= n - fwd) ? pl : mi;
    endfunction

    function automatic int model_port(int dx, int dy, int dz);
        if (dx != my_x) return pick_dir(my_x, dx, ring_x, 0, 1);
        if (dy != my_y) return pick_dir(my_y, dy, ring_y, 2, 3);
        if (dz != my_z) return pick_dir(my_z, dz, ring_z, 4, 5);
        return 6;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic send_pkt(input int src, input int dx, input int dy, input int dz,
                            input int nbody);
        int o;
        o = model_port(dx, dy, dz);
        for (int f = 0; f <= nbody; f++) begin
            logic [DW-1:0] d;
            d = '0;
            d[127:124] = 4'(src);
            d[123:112] = 12'(seq);
            seq++;
            if (f == 0) begin
                d[3:0] = 4'(dx); d[7:4] = 4'(dy); d[11:8] = 4'(dz);
                d[23:12] = 12'(nbody);
            end else d[63:32] = 32'hB0D0_0000 + 32'(f);
            exp_q[o*NP + src].push_back({f == nbody, d});
            @(negedge clk);
            drv[src] = d; in_eop[src] = (f == nbody); in_valid[src] = 1'b1;
            while (!in_ready[src]) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid[src] = 1'b0;
    endtask

    task automatic drain();
        int left;
        for (int t = 0; t < 400; t++) begin
            left = 0;
            for (int k = 0; k < NP*NP; k++) left += exp_q[k].size();
            if (left == 0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    logic [DW:0] got, want;
                    int s;
                    got = {out_eop[o], out_data[o*DW +: DW]};
                    if (cur_src[o] < 0) begin
                        s = int'(got[127:124]);
                        if (o == 6) order_q.push_back(s);
                        if (exp_q[o*NP + s].size() == 0) begin
                            check(0, "R2 R3 R4 R5", $sformatf("misrouted header on out %0d", o),
                                  o, s);
                        end else begin
                            want = exp_q[o*NP + s].pop_front();
                            check(got == want, "R9", $sformatf("header on out %0d", o),
                                  got[63:0], want[63:0]);
                        end
                    end else begin
                        s = cur_src[o];
                        if (exp_q[o*NP + s].size() == 0)
                            check(0, "R6", "extra body flit", got[63:0], 0);
                        else begin
                            want = exp_q[o*NP + s].pop_front();
                            check(got == want, "R6", $sformatf("body flit on out %0d", o),
                                  got[127:64], want[127:64]);
                        end
                    end
                    cur_src[o] = got[DW] ? -1 : s;
                end
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) begin drv[i] = '0; cur_src[i] = -1; end
        repeat (3) @(negedge clk);
        // R1
        check(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready == '1, "R1", "in_ready in reset", in_ready, 7'h7f);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == '1, "R1", "in_ready after reset", in_ready, 7'h7f);

        // R7 round 1: pointer at 0, inputs 1 and 3 race for local
        fork
            send_pkt(1, 2, 3, 1, 1);
            send_pkt(3, 2, 3, 1, 1);
        join
        drain();
        check(order_q.size() == 2 && order_q[0] == 1 && order_q[1] == 3, "R7",
              "round 1 first winner", order_q.size() > 0 ? order_q[0] : -1, 1);
        order_q.delete();
        // R7 round 2: pointer now 4, inputs 0 and 4 race
        fork
            send_pkt(0, 2, 3, 1, 2);
            send_pkt(4, 2, 3, 1, 2);
        join
        drain();
        check(order_q.size() == 2 && order_q[0] == 4 && order_q[1] == 0, "R7",
              "round 2 first winner", order_q.size() > 0 ? order_q[0] : -1, 4);

        // R2 R3 R4 R5 single packets
        send_pkt(6, 2, 3, 1, 1);   // R2 local
        send_pkt(6, 5, 3, 1, 2);   // R4 short plus X
        send_pkt(6, 7, 3, 1, 1);   // R4 wrap minus X
        send_pkt(6, 6, 3, 1, 1);   // R4 tie -> plus
        send_pkt(2, 2, 0, 1, 1);   // R4 Y minus
        send_pkt(6, 2, 3, 3, 0);   // R4 Z tie on ring 4
        send_pkt(0, 2, 3, 0, 1);   // R4 Z minus
        send_pkt(6, 4, 0, 0, 2);   // R3 X first
        send_pkt(5, 2, 6, 3, 1);   // R3 Y before Z
        drain();
        ring_x = 5'd4;
        send_pkt(6, 0, 3, 1, 1);   // R4 ring 4: tie -> X+
        drain();
        ring_x = 5'd8;
        send_pkt(6, 0, 3, 1, 1);   // R4 ring 8: -> X-
        drain();

        // R6 two inputs to one output with long packets
        fork
            send_pkt(1, 6, 3, 1, 5);
            send_pkt(2, 6, 3, 1, 5);
        join
        drain();

        // R8 stall and backpressure
        @(posedge clk); #1 out_ready[6] = 1'b0;
        fork
            send_pkt(0, 2, 3, 1, 6);
        join_none
        repeat (20) @(negedge clk);
        check(in_ready[0] == 1'b0, "R8", "in_ready when fifo full", in_ready[0], 0);
        check(out_valid[6] == 1'b1, "R8", "valid held in stall", out_valid[6], 1);
        begin
            logic [DW-1:0] snap;
            snap = out_data[6*DW +: DW];
            repeat (3) @(negedge clk);
            check(out_data[6*DW +: DW] == snap && out_valid[6], "R8", "data held in stall",
                  out_data[6*DW +: 64], snap[63:0]);
        end
        @(posedge clk); #1 out_ready[6] = 1'b1;
        wait fork;
        drain();

        // R9 everything delivered
        begin
            int left;
            left = 0;
            for (int k = 0; k < NP*NP; k++) left += exp_q[k].size();
            check(left == 0, "R9", "undelivered flits", left, 0);
        end
        finish_run();
    end
endmodule